// File: doc/BRIEF.md
# UART Receive Status and Interrupt Qualifier

This block sits between a UART character deserializer and a CPU register port. When a character finishes, the deserializer presents the byte together with four indications for one cycle: the stop bit was sampled low, the parity check failed, a break was seen, and the character carries the address mark. The block then judges the character. It decides whether the byte enters the receive buffer, records error and wake-up state in an 8-bit status/control register, and raises a receive interrupt flag. Two filters apply: an error-acceptance mode, and an address-only wake-up mode.

Software reads and writes the status/control register through a plain write strobe and a read-data bus. It collects the byte with a buffer-read strobe. That read also clears the interrupt flag and the summary error bit. The character input is a valid-only stream with no back-pressure. Every valid cycle is a finished character. The block cannot stall the line, so a byte that arrives while the buffer still holds an unread byte overwrites it and is reported as an overrun.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `reg_rdata`, `rxbuf_data` and `rx_irq` are all 0.
- R2: The status/control register has this bit order, from bit 7 down to bit 0: framing error, parity error, overrun, break, error-accept enable, wake-up enable, address flag, summary error. A write on `reg_wr` replaces all eight bits, and the new value is readable on the next cycle.
- R3: An arriving character sets the framing flag (bit 7) when its stop bit was low, and the break flag (bit 4) when a break was seen. With `parity_en` = 1, it sets the parity flag (bit 6) when parity failed. These flags stay set until software writes 0 to them.
- R4: While `parity_en` = 0, bit 6 reads as 0, a parity failure sets no flag, and a parity failure does not count as an error.
- R5: A character loaded into the buffer while the previous byte is unread, with no buffer read in that cycle, sets the overrun flag (bit 5).
- R6: With bit 3 = 0, a character with a framing, parity or break error is rejected. `rxbuf_data` keeps its value and `rx_irq` is not set. With bit 3 = 1, such a character is loaded and can set `rx_irq`.
- R7: With bit 2 = 1, only loaded characters marked as addresses set `rx_irq`. With bit 2 = 0, every loaded character sets it.
- R8: Each loaded character copies its address mark into bit 1. Rejected characters leave bit 1 unchanged.
- R9: Bit 0 is set whenever an arrival sets any of the bits 7, 6, 5 or 4. A buffer read clears bit 0.
- R10: A buffer read (`rxbuf_rd`) clears `rx_irq` and marks the buffer as read. It leaves bits 7 to 4 unchanged. `rxbuf_data` shows the last loaded byte.
- R11: When a buffer read and a character arrival fall in the same cycle, the arrival wins. The flags, bit 0 and `rx_irq` it sets end up set. No overrun is reported for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| parity_en | input | 1 | Parity checking enabled |
| char_valid | input | 1 | A finished character is presented this cycle |
| char_data | input | 8 | Received byte |
| char_stop_bad | input | 1 | Stop bit sampled low |
| char_parity_bad | input | 1 | Parity check failed |
| char_break | input | 1 | Break condition detected |
| char_is_addr | input | 1 | Character carries the address mark |
| reg_wr | input | 1 | Write strobe for the status/control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Status/control register value |
| rxbuf_rd | input | 1 | Buffer read strobe |
| rxbuf_data | output | 8 | Receive buffer |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
A buffer read and a character arrival can land in the same cycle. The buffer read clears the interrupt flag and the summary error bit, while the arrival sets them. The bench provokes this by first loading a clean byte. On the next cycle it raises `rxbuf_rd` together with a character that carries a break, with error acceptance enabled. The outcome passes when, one cycle later, `rx_irq`, the break flag and the summary bit are all 1, the overrun flag is 0, and the new byte is in the buffer.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_FE   = 7;
  localparam int BIT_PE   = 6;
  localparam int BIT_OE   = 5;
  localparam int BIT_BRK  = 4;
  localparam int BIT_EIE  = 3;
  localparam int BIT_WIE  = 2;
  localparam int BIT_WAKE = 1;
  localparam int BIT_ERR  = 0;

  typedef struct packed {
    logic stop_bad;
    logic parity_bad;
    logic brk;
    logic is_addr;
  } char_flags_t;

  typedef struct packed {
    logic fe;
    logic pe;
    logic oe;
    logic brk;
  } err_set_t;
endpackage

// File: rtl/uart_rx_classify.sv
module uart_rx_classify
  import uart_rx_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  char_flags_t flags,
  input  logic        parity_en,
  input  logic        err_accept,
  input  logic        wake_only,
  input  logic        buf_unread,
  input  logic        buf_rd,
  output logic        load,
  output logic        set_irq,
  output err_set_t    errs,
  output logic        any_err
);
  logic line_err;

  always_comb begin
    line_err = flags.stop_bad | (flags.parity_bad & parity_en) | flags.brk;
    load     = valid & (~line_err | err_accept);
    errs.fe  = valid & flags.stop_bad;
    errs.pe  = valid & flags.parity_bad & parity_en;
    errs.brk = valid & flags.brk;
    errs.oe  = load & buf_unread & ~buf_rd;
    any_err  = errs.fe | errs.pe | errs.oe | errs.brk;
    set_irq  = load & (~wake_only | flags.is_addr);
  end

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !err_accept && (flags.stop_bad || flags.brk)) |-> !load && !set_irq);
  // R7
  wake_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_only && !flags.is_addr) |-> !set_irq);
  // R4
  parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !parity_en |-> !errs.pe);
endmodule

// File: rtl/uart_rx_statreg.sv
module uart_rx_statreg
  import uart_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic              buf_rd,
  input  logic              parity_en,
  input  err_set_t          errs,
  input  logic              any_err,
  input  logic              load,
  input  logic              is_addr,
  output logic              err_accept,
  output logic              wake_only,
  output logic [STAT_W-1:0] rdata
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [STAT_W-1:0] read_mask;

  always_comb begin
    stat_d = wr ? wdata : stat_q;
    if (buf_rd && !wr) stat_d[BIT_ERR] = 1'b0;
    stat_d[BIT_FE]  = stat_d[BIT_FE]  | errs.fe;
    stat_d[BIT_PE]  = stat_d[BIT_PE]  | errs.pe;
    stat_d[BIT_OE]  = stat_d[BIT_OE]  | errs.oe;
    stat_d[BIT_BRK] = stat_d[BIT_BRK] | errs.brk;
    if (load)    stat_d[BIT_WAKE] = is_addr;
    if (any_err) stat_d[BIT_ERR]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_comb begin
    read_mask         = '1;
    read_mask[BIT_PE] = parity_en;
    rdata             = stat_q & read_mask;
    err_accept        = stat_q[BIT_EIE];
    wake_only         = stat_q[BIT_WIE];
  end

  // R3
  fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errs.fe |=> stat_q[BIT_FE]);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[BIT_BRK] && !wr) |=> stat_q[BIT_BRK]);
  // R9
  errsum_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> stat_q[BIT_ERR]);
  // R9
  errsum_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !any_err && !wr) |=> !stat_q[BIT_ERR]);
  // R8
  wake_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stat_q[BIT_WAKE] == $past(is_addr));
endmodule

// File: rtl/uart_rx_bufctl.sv
module uart_rx_bufctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              set_irq,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] buf_data,
  output logic              unread,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0;
      unread   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (load) buf_data <= data;
      if (load)        unread <= 1'b1;
      else if (buf_rd) unread <= 1'b0;
      if (set_irq)     irq <= 1'b1;
      else if (buf_rd) irq <= 1'b0;
    end
  end

  // R6
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(buf_data));
  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !set_irq) |=> !irq);
  // R11
  arrival_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && set_irq) |=> irq && unread);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              parity_en,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_stop_bad,
  input  logic              char_parity_bad,
  input  logic              char_break,
  input  logic              char_is_addr,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic              rxbuf_rd,
  output logic [DATA_W-1:0] rxbuf_data,
  output logic              rx_irq
);
  char_flags_t flags;
  err_set_t    errs;
  logic        load, set_irq, any_err;
  logic        err_accept, wake_only, unread;

  assign flags = '{stop_bad: char_stop_bad, parity_bad: char_parity_bad,
                   brk: char_break, is_addr: char_is_addr};

  uart_rx_classify u_classify (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (char_valid),
    .flags      (flags),
    .parity_en  (parity_en),
    .err_accept (err_accept),
    .wake_only  (wake_only),
    .buf_unread (unread),
    .buf_rd     (rxbuf_rd),
    .load       (load),
    .set_irq    (set_irq),
    .errs       (errs),
    .any_err    (any_err)
  );

  uart_rx_statreg u_statreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .buf_rd     (rxbuf_rd),
    .parity_en  (parity_en),
    .errs       (errs),
    .any_err    (any_err),
    .load       (load),
    .is_addr    (char_is_addr),
    .err_accept (err_accept),
    .wake_only  (wake_only),
    .rdata      (reg_rdata)
  );

  uart_rx_bufctl #(.DATA_W(DATA_W)) u_bufctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .data     (char_data),
    .set_irq  (set_irq),
    .buf_rd   (rxbuf_rd),
    .buf_data (rxbuf_data),
    .unread   (unread),
    .irq      (rx_irq)
  );

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && unread && !rxbuf_rd && !reg_wr) |=> reg_rdata[BIT_OE]);
  // R4
  pe_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!parity_en && $stable(parity_en)) |-> !reg_rdata[BIT_PE]);
endmodule

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       parity_en = 1'b0;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_stop_bad = 1'b0, char_parity_bad = 1'b0;
  logic       char_break = 1'b0, char_is_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rxbuf_rd = 1'b0;
  logic [7:0] rxbuf_data;
  logic       rx_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_status uut (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; rxbuf_rd = 0; char_valid = 0;
    char_stop_bad = 0; char_parity_bad = 0; char_break = 0; char_is_addr = 0;
  endtask

  task automatic setup(logic [7:0] ctrl);
    reg_wr = 1; reg_wdata = ctrl; rxbuf_rd = 1;
    step(); idle();
  endtask

  task automatic send(logic [7:0] d, logic fe, logic pe, logic brk, logic addr);
    char_valid = 1; char_data = d; char_stop_bad = fe;
    char_parity_bad = pe; char_break = brk; char_is_addr = addr;
  endtask

  initial begin
    logic [7:0] exp_buf;
    exp_buf = 8'h00;
    idle();
    repeat (3) step();
    // R1 reset state
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 buf", rxbuf_data, 8'h00);
    chk("R1 irq", {7'd0, rx_irq}, 8'h00);
    rst_n = 1;
    step();

    // R2 / R4 register write-read
    parity_en = 1;
    reg_wr = 1; reg_wdata = 8'hA5; step(); idle();
    chk("R2 write A5", reg_rdata, 8'hA5);
    reg_wr = 1; reg_wdata = 8'hFF; step(); idle();
    chk("R2 write FF", reg_rdata, 8'hFF);
    parity_en = 0; step();
    chk("R4 pe masked", reg_rdata, 8'hBF);
    reg_wr = 1; reg_wdata = 8'h00; step(); idle();
    chk("R2 write 00", reg_rdata, 8'h00);

    // Sweep: R3 R4 R6 R7 R8 R9
    for (int i = 0; i < 128; i++) begin
      logic eie, wie, pen, fe, pe, brk, addr, le, ld, irq;
      logic [7:0] er;
      {eie, wie, pen, fe, pe, brk, addr} = i[6:0];
      parity_en = pen;
      setup({4'b0000, eie, wie, 2'b00});
      send(8'(i * 3 + 1), fe, pe, brk, addr);
      step(); idle();
      le  = fe | (pe & pen) | brk;
      ld  = ~le | eie;
      irq = ld & (~wie | addr);
      if (ld) exp_buf = 8'(i * 3 + 1);
      er = {fe, pe & pen, 1'b0, brk, eie, wie, ld & addr, le};
      chk($sformatf("R3/R4/R8/R9 reg case %0d", i), reg_rdata, er);
      chk($sformatf("R6/R7 irq case %0d", i), {7'd0, rx_irq}, {7'd0, irq});
      chk($sformatf("R6 buf case %0d", i), rxbuf_data, exp_buf);
    end

    // R5 overrun
    parity_en = 1;
    setup(8'h00);
    send(8'h11, 0, 0, 0, 1); step(); idle();
    send(8'h22, 0, 0, 0, 0); step(); idle();
    chk("R5 overrun reg", reg_rdata, 8'h21);
    chk("R5 overrun buf", rxbuf_data, 8'h22);
    // R10 read clears irq and summary, keeps flags
    rxbuf_rd = 1; step(); idle();
    chk("R10 reg after read", reg_rdata, 8'h20);
    chk("R10 irq after read", {7'd0, rx_irq}, 8'h00);
    chk("R10 buf after read", rxbuf_data, 8'h22);

    // R3 sticky flag
    setup(8'h08);
    send(8'h33, 1, 0, 0, 0); step(); idle();
    rxbuf_rd = 1; step(); idle();
    send(8'h44, 0, 0, 0, 0); step(); idle();
    chk("R3 sticky fe", reg_rdata, 8'h88);
    chk("R3 sticky irq", {7'd0, rx_irq}, 8'h01);

    // R11 read and arrival in same cycle
    setup(8'h08);
    send(8'h55, 0, 0, 0, 0); step(); idle();
    rxbuf_rd = 1;
    send(8'h66, 0, 0, 1, 0); step(); idle();
    chk("R11 reg", reg_rdata, 8'h19);
    chk("R11 irq", {7'd0, rx_irq}, 8'h01);
    chk("R11 buf", rxbuf_data, 8'h66);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule